// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block keeps the instruction fetch address of a pipeline and steers it. It holds a direct-mapped table with one entry per index. Each entry records the word address of a simple direct branch (conditional or unconditional), where that branch goes, and whether it went there the last time it was resolved. While fetch steps forward one word at a time, the block compares the current fetch address with the entry it has already read for it. On a match with a live entry, the next fetch goes to the stored target, and that fetch is flagged as predicted-taken. A fetch without the flag is left to static prediction further down the pipe.

The table read runs two words ahead of fetch, so the index lookup and the tag compare fall in different cycles. The cost is that the two fetches after any change of flow cannot be predicted. This applies to a redirect from a later stage and to a redirect made by the table itself. The execute stage writes the table on every resolved simple branch, whether taken or not. All addresses on the ports are word addresses, meaning byte address bits [31:2].

The fetch output is a valid/ready stream. With `fetch_ready` low, the fetch word, the flag and the read-ahead pipeline all hold, and the table redirects nothing. `fetch_valid` is low only during reset. The update port has no ready signal: a write is accepted in every cycle in which `upd_valid` is high. A later-stage redirect is also taken in every cycle, stalled or not.

Top module: `btc_fetch_predictor`

## Requirements
- R1: While reset is asserted, `fetch_valid` is 0, `fetch_word` equals RESET_WORD and `fetch_pred_taken` is 0. Reset invalidates every table entry, so no prediction follows until the table is written again.
- R2: In a cycle with `fetch_ready` high, no `redir_valid` and no table hit, the next `fetch_word` is the current value plus 1 and `fetch_pred_taken` is 0.
- R3: `redir_valid` high in any cycle, stalled or not, loads `redir_word` into `fetch_word` at the next edge with `fetch_pred_taken` 0. It takes priority over a table hit in the same cycle.
- R4: A hit needs three things: an advancing fetch, an entry marked taken, and a stored branch word equal to `fetch_word`. On a hit, the next `fetch_word` is the stored target and `fetch_pred_taken` is 1 for that fetch only.
- R5: `upd_valid` writes the branch word and target into the entry indexed by `upd_word[IDX_W-1:0]`. The entry is marked taken when `upd_taken` is 1 and cleared when it is 0, so a not-taken outcome removes the prediction.
- R6: The hit compare uses all WORD_W stored bits. Two branches that share index bits [IDX_W-1:0] but differ above them never cause a false redirect; only the last one written can hit.
- R7: After a later-stage redirect to word T, fetches of T and T+1 are never predicted. The fetch of T+2 and later sequential fetches can be.
- R8: A table redirect to target T restarts the read-ahead in the same way: the fetches of T+1 and T+2... precisely, the first two fetches after T (at T and T+1) cannot be predicted, and the third (T+2) can.
- R9: While `fetch_ready` is low and `redir_valid` is low, `fetch_word` and `fetch_pred_taken` hold, and a pending hit is issued only once fetch advances.
- R10: When an update and the read-ahead access the same index in one cycle, the read returns the contents from before the write.
- R11: With ENABLE = 0 the block never redirects on its own and `fetch_pred_taken` stays 0; fetch only steps sequentially or follows `redir_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_ready | input | 1 | Downstream accepts the current fetch; low means stall |
| fetch_valid | output | 1 | Fetch word is valid (high after reset) |
| fetch_word | output | WORD_W | Current fetch word address |
| fetch_pred_taken | output | 1 | This fetch was reached through a predicted-taken branch |
| redir_valid | input | 1 | Later-stage redirect request |
| redir_word | input | WORD_W | Redirect target word address |
| upd_valid | input | 1 | Resolved simple branch from execute |
| upd_word | input | WORD_W | Word address of the resolved branch |
| upd_target | input | WORD_W | Target word address of the resolved branch |
| upd_taken | input | 1 | 1 when the branch was taken |

## Verification
Two pairs of functions can fall in the same cycle. An execute-stage write can land in the cycle in which the read-ahead fetches the same index. The bench provokes this by redirecting two words before a trained branch and clearing that branch in the very next cycle. It then expects the prediction to fire once from the old contents and to be gone on the following walk. A later-stage redirect can also coincide with a live table hit. The bench issues one exactly while fetch sits on a trained branch, and again during a stall, and judges both by the fetch word and the flag that follow.

// File: rtl/btc_pkg.sv
package btc_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_SEQ  = 2'd1,
    SRC_PRED = 2'd2,
    SRC_EXT  = 2'd3
  } next_src_e;
endpackage

// File: rtl/btc_store.sv
module btc_store #(
  parameter int WORD_W = 30,
  parameter int IDX_W  = 10,
  parameter bit ENABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_br,
  input  logic [WORD_W-1:0] wr_tgt,
  input  logic              wr_taken,
  output logic              rd_vld,
  output logic [WORD_W-1:0] rd_br,
  output logic [WORD_W-1:0] rd_tgt
);
  localparam int DEPTH = 1 << IDX_W;

  generate
    if (ENABLE) begin : g_table
      logic [WORD_W-1:0] br_mem  [DEPTH];
      logic [WORD_W-1:0] tgt_mem [DEPTH];
      logic [DEPTH-1:0]  taken_q;
      logic [IDX_W-1:0]  wr_idx;

      assign wr_idx = wr_br[IDX_W-1:0];

      // data arrays: no reset, read-before-write through nonblocking order
      always_ff @(posedge clk) begin
        if (rd_en) begin
          rd_br  <= br_mem[rd_idx];
          rd_tgt <= tgt_mem[rd_idx];
        end
        if (wr_en) begin
          br_mem[wr_idx]  <= wr_br;
          tgt_mem[wr_idx] <= wr_tgt;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          taken_q <= '0;
          rd_vld  <= 1'b0;
        end else begin
          if (rd_en) rd_vld <= taken_q[rd_idx];
          if (wr_en) taken_q[wr_idx] <= wr_taken;
        end
      end
    end else begin : g_none
      assign rd_vld = 1'b0;
      assign rd_br  = '0;
      assign rd_tgt = '0;
    end
  endgenerate
endmodule

// File: rtl/btc_lookahead.sv
module btc_lookahead #(
  parameter int WORD_W = 30,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              flush,
  input  logic [WORD_W-1:0] pc_word,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_vld,
  input  logic [WORD_W-1:0] rd_br,
  input  logic [WORD_W-1:0] rd_tgt,
  output logic              hit,
  output logic [WORD_W-1:0] hit_tgt
);
  localparam int AHEAD = 2;

  logic [WORD_W-1:0] ahead_word;
  logic              s1_ok;
  logic              s2_vld;
  logic [WORD_W-1:0] s2_br;
  logic [WORD_W-1:0] s2_tgt;

  assign ahead_word = pc_word + WORD_W'(AHEAD);
  assign rd_en      = adv;
  assign rd_idx     = ahead_word[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_ok  <= 1'b0;
      s2_vld <= 1'b0;
    end else if (flush) begin
      s1_ok  <= 1'b0;
      s2_vld <= 1'b0;
    end else if (adv) begin
      s1_ok  <= 1'b1;
      s2_vld <= s1_ok & rd_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s2_br  <= rd_br;
      s2_tgt <= rd_tgt;
    end
  end

  assign hit     = s2_vld && (s2_br == pc_word);
  assign hit_tgt = s2_tgt;

  // a flush empties the read-ahead, so the next cycle cannot hit
  assert_flush_blocks_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit);
endmodule

// File: rtl/btc_fetch_predictor.sv
module btc_fetch_predictor #(
  parameter int                 WORD_W     = 30,
  parameter int                 IDX_W      = 10,
  parameter bit                 ENABLE     = 1'b1,
  parameter logic [WORD_W-1:0]  RESET_WORD = 30'h0000_0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_ready,
  output logic              fetch_valid,
  output logic [WORD_W-1:0] fetch_word,
  output logic              fetch_pred_taken,
  input  logic              redir_valid,
  input  logic [WORD_W-1:0] redir_word,
  input  logic              upd_valid,
  input  logic [WORD_W-1:0] upd_word,
  input  logic [WORD_W-1:0] upd_target,
  input  logic              upd_taken
);
  import btc_pkg::*;

  logic              adv;
  logic              take;
  logic              flush;
  logic              rd_en;
  logic [IDX_W-1:0]  rd_idx;
  logic              rd_vld;
  logic [WORD_W-1:0] rd_br;
  logic [WORD_W-1:0] rd_tgt;
  logic              hit;
  logic [WORD_W-1:0] hit_tgt;
  next_src_e         src;

  assign adv   = fetch_ready;
  assign take  = ENABLE && adv && hit && !redir_valid;
  assign flush = redir_valid || take;

  btc_store #(.WORD_W(WORD_W), .IDX_W(IDX_W), .ENABLE(ENABLE)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .wr_en    (upd_valid),
    .wr_br    (upd_word),
    .wr_tgt   (upd_target),
    .wr_taken (upd_taken),
    .rd_vld   (rd_vld),
    .rd_br    (rd_br),
    .rd_tgt   (rd_tgt)
  );

  btc_lookahead #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_ahead (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .flush   (flush),
    .pc_word (fetch_word),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_vld  (rd_vld),
    .rd_br   (rd_br),
    .rd_tgt  (rd_tgt),
    .hit     (hit),
    .hit_tgt (hit_tgt)
  );

  always_comb begin
    if (redir_valid)  src = SRC_EXT;
    else if (take)    src = SRC_PRED;
    else if (adv)     src = SRC_SEQ;
    else              src = SRC_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_valid      <= 1'b0;
      fetch_word       <= RESET_WORD;
      fetch_pred_taken <= 1'b0;
    end else begin
      fetch_valid <= 1'b1;
      unique case (src)
        SRC_EXT: begin
          fetch_word       <= redir_word;
          fetch_pred_taken <= 1'b0;
        end
        SRC_PRED: begin
          fetch_word       <= hit_tgt;
          fetch_pred_taken <= 1'b1;
        end
        SRC_SEQ: begin
          fetch_word       <= fetch_word + WORD_W'(1);
          fetch_pred_taken <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assert_step_sequential_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready && !redir_valid && !hit) |=>
      (fetch_word == $past(fetch_word) + WORD_W'(1)) && !fetch_pred_taken);

  assert_redirect_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (fetch_word == $past(redir_word)) && !fetch_pred_taken);

  assert_hit_goes_to_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ENABLE && fetch_ready && hit && !redir_valid) |=>
      (fetch_word == $past(hit_tgt)) && fetch_pred_taken);

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_ready && !redir_valid) |=> $stable(fetch_word) && $stable(fetch_pred_taken));

  generate
    if (!ENABLE) begin : g_off_chk
      assert_never_flag_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |=> !fetch_pred_taken);
    end
  endgenerate
endmodule

// File: tb/btc_fetch_predictor_bench.sv
module btc_fetch_predictor_bench;
  localparam int WW = 30;
  localparam logic [31:0] RST_BYTE = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_ready = 1'b1;
  logic          redir_valid = 1'b0;
  logic [WW-1:0] redir_word = '0;
  logic          upd_valid = 1'b0;
  logic [WW-1:0] upd_word = '0;
  logic [WW-1:0] upd_target = '0;
  logic          upd_taken = 1'b0;

  logic          fv, fp, fv_off, fp_off;
  logic [WW-1:0] fw, fw_off;

  int checks = 0;
  int errors = 0;
  int off_flags = 0;

  always #10 clk = ~clk;

  btc_fetch_predictor u_btc_fetch_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_ready(fetch_ready),
    .fetch_valid(fv), .fetch_word(fw), .fetch_pred_taken(fp),
    .redir_valid(redir_valid), .redir_word(redir_word),
    .upd_valid(upd_valid), .upd_word(upd_word), .upd_target(upd_target),
    .upd_taken(upd_taken));

  btc_fetch_predictor #(.ENABLE(1'b0)) u_btc_off (
    .clk(clk), .rst_n(rst_n), .fetch_ready(fetch_ready),
    .fetch_valid(fv_off), .fetch_word(fw_off), .fetch_pred_taken(fp_off),
    .redir_valid(redir_valid), .redir_word(redir_word),
    .upd_valid(upd_valid), .upd_word(upd_word), .upd_target(upd_target),
    .upd_taken(upd_taken));

  always @(negedge clk) if (rst_n && fp_off) off_flags++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_at(input string tag, input logic [31:0] byte_addr, input logic pred);
    check({tag, " addr"}, {fw, 2'b00}, byte_addr);
    check({tag, " flag"}, {31'd0, fp}, {31'd0, pred});
  endtask

  task automatic redirect(input logic [31:0] byte_addr);
    redir_valid = 1'b1;
    redir_word  = byte_addr[31:2];
    tick();
    redir_valid = 1'b0;
  endtask

  task automatic train(input logic [31:0] br, input logic [31:0] tgt, input logic tk);
    upd_valid  = 1'b1;
    upd_word   = br[31:2];
    upd_target = tgt[31:2];
    upd_taken  = tk;
    tick();
    upd_valid  = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid in reset", {31'd0, fv}, 32'd0);
    expect_at("R1 reset", RST_BYTE, 1'b0);
    rst_n = 1'b1;
    check("R1 valid after reset", {31'd0, fv}, 32'd0);
    tick();
    check("R1 valid after edge", {31'd0, fv}, 32'd1);
  endtask

  task automatic t_sequential();
    expect_at("R2 step1", RST_BYTE + 4, 1'b0);
    tick();
    expect_at("R2 step2", RST_BYTE + 8, 1'b0);
    tick();
    expect_at("R2 step3", RST_BYTE + 12, 1'b0);
  endtask

  task automatic t_train_hit();
    train(32'h2010, 32'h3000, 1'b1);
    redirect(32'h2000);
    expect_at("R7 redirect lands", 32'h2000, 1'b0);
    for (int i = 1; i <= 4; i++) begin
      tick();
      expect_at("R4 walk", 32'h2000 + 32'(4 * i), 1'b0);
    end
    tick();
    expect_at("R4 predicted target", 32'h3000, 1'b1);
    check("R11 disabled copy sequential", {fw_off, 2'b00}, 32'h2014);
    tick();
    expect_at("R4 flag one fetch only", 32'h3004, 1'b0);
  endtask

  task automatic t_third_fetch();
    redirect(32'h2010);
    tick();
    expect_at("R7 first fetch not predicted", 32'h2014, 1'b0);
    redirect(32'h200C);
    tick();
    tick();
    expect_at("R7 second fetch not predicted", 32'h2014, 1'b0);
    redirect(32'h2008);
    tick();
    tick();
    tick();
    expect_at("R7 third fetch predicted", 32'h3000, 1'b1);
  endtask

  task automatic t_restart();
    train(32'h3004, 32'h4000, 1'b1);
    train(32'h3008, 32'h4100, 1'b1);
    redirect(32'h2008);
    tick(); tick(); tick();
    expect_at("R8 first hit", 32'h3000, 1'b1);
    tick();
    expect_at("R8 second after hit not predicted", 32'h3004, 1'b0);
    tick();
    expect_at("R8 third after hit not predicted yet", 32'h3008, 1'b0);
    tick();
    expect_at("R8 third fetch predicted", 32'h4100, 1'b1);
  endtask

  task automatic t_stall();
    redirect(32'h2008);
    tick(); tick();
    expect_at("R9 at branch", 32'h2010, 1'b0);
    fetch_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      expect_at("R9 held on branch", 32'h2010, 1'b0);
    end
    fetch_ready = 1'b1;
    tick();
    expect_at("R9 hit after stall", 32'h3000, 1'b1);
    fetch_ready = 1'b0;
    tick(); tick();
    expect_at("R9 flag held", 32'h3000, 1'b1);
    fetch_ready = 1'b1;
    tick();
    expect_at("R9 resume", 32'h3004, 1'b0);
  endtask

  task automatic t_priority();
    redirect(32'h2008);
    tick(); tick();
    redirect(32'h7000);
    expect_at("R3 beats hit", 32'h7000, 1'b0);
    fetch_ready = 1'b0;
    redirect(32'h7100);
    expect_at("R3 during stall", 32'h7100, 1'b0);
    fetch_ready = 1'b1;
  endtask

  task automatic t_alias();
    train(32'h3010, 32'h5000, 1'b1);
    redirect(32'h2008);
    tick(); tick(); tick();
    expect_at("R6 no alias hit", 32'h2014, 1'b0);
    redirect(32'h3008);
    tick(); tick(); tick();
    expect_at("R6 new owner hits", 32'h5000, 1'b1);
  endtask

  task automatic t_same_cycle();
    train(32'h2010, 32'h3000, 1'b1);
    redirect(32'h2008);
    upd_valid = 1'b1; upd_word = 30'h804; upd_target = 30'hC00; upd_taken = 1'b0;
    tick();
    upd_valid = 1'b0;
    tick(); tick();
    expect_at("R10 old contents used", 32'h3000, 1'b1);
    redirect(32'h2008);
    tick(); tick(); tick();
    expect_at("R5 not-taken cleared", 32'h2014, 1'b0);
  endtask

  task automatic t_reset_clears();
    train(32'h2010, 32'h3000, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    expect_at("R1 mid-run reset", RST_BYTE, 1'b0);
    rst_n = 1'b1;
    redirect(32'h2008);
    tick(); tick(); tick();
    expect_at("R1 entries invalid after reset", 32'h2014, 1'b0);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_sequential();
    t_train_hit();
    t_third_fetch();
    t_restart();
    t_stall();
    t_priority();
    t_alias();
    t_same_cycle();
    t_reset_clears();
    check("R11 disabled copy never flagged", 32'(off_flags), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule